// File: doc/BRIEF.md
# External Interrupt Pin Controller

The block watches a set of external interrupt pins (five by default). Each pin is first brought into the clock domain through a short synchronizer. Its edges are then detected, and a detected edge sets a sticky request flag. Each pin has an 8-bit control register on a byte-wide register bus. That register holds a 3-bit priority level, the request flag, an edge polarity bit and a reserved bit. One further select register turns on detection of both edges for each pin separately.

Downstream, an arbiter gets two things for each pin. The first is a request line, which is the flag qualified by a nonzero level. The second is the pin's level field. Software sees a pending request by reading the flag. It removes the request by writing 0 to the flag. Writing 1 to the flag does nothing, so software can never raise a request on its own.

Reads are combinational from the address. Pin `i`'s control register sits at address `i`, and the both-edges select register sits at address `NUM_PINS`. Every other address reads as zero.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every control register and the select register read 0x00, `reqOut` is all zero and `levelOut` is all zero.
- R2: A control register stores bits 2:0 (level), 4 (polarity) and 5 (reserved) as written and returns them on read. Bits 7:6 always read 0. The select register returns bits NUM_PINS-1:0 as written and reads 0 above them. Unmapped addresses read 0x00. A write to one register leaves all other registers unchanged.
- R3: With polarity bit 4 = 0 and the pin's select bit = 0, a falling edge on the pin sets flag bit 3 and a rising edge does not.
- R4: With polarity bit 4 = 1 and the pin's select bit = 0, a rising edge sets the flag and a falling edge does not.
- R5: With the pin's select bit = 1 (polarity 0), both rising and falling edges set the flag.
- R6: Writing 0 to bit 3 clears the flag. Writing 1 to bit 3 leaves the flag unchanged, whether it is set or clear.
- R7: If an edge detection and a software clear of the same pin take effect on the same clock edge, the flag ends set.
- R8: `reqOut[i]` is 1 exactly when pin i's flag is set and its level is nonzero. A flag set while the level is 0 still latches and reads back as 1.
- R9: `levelOut[3*i+2:3*i]` carries pin i's level field.
- R10: A pin change driven before clock edge k sets the flag at edge k+2 and not earlier. The flag then stays set when the pin returns to its previous value, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Asynchronous external interrupt pins |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| reqOut | output | NUM_PINS | Qualified request per pin to the arbiter |
| levelOut | output | 3*NUM_PINS | Priority level per pin, 3 bits each |

## Verification
The bench targets the same-edge collision between a detected edge and a software clear. If the clear wins there, an interrupt is silently lost. It checks that writing 1 to the flag neither sets an idle flag nor disturbs a pending one; a plain read-modify-write flag would fail both. It checks that the wrong edge is ignored under each polarity, and that the both-edges select overrides polarity. It times the flag exactly two edges after synchronization, which exposes a missing or extra synchronizer stage. Finally, it sets a flag while the level is zero and then raises the level, to show that the request is gated by the level and not dropped.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int IDX_W    = 3;
  localparam int LVL_W    = 3;
  localparam int FLAG_BIT = 3;
  localparam int POL_BIT  = 4;
  localparam int RSV_BIT  = 5;

  typedef struct packed {
    logic             wrCtrl;
    logic             wrSel;
    logic             rdCtrl;
    logic             rdSel;
    logic [IDX_W-1:0] pinIdx;
    logic [7:0]       wdata;
  } strobe_t;
endpackage

// File: rtl/extirq_decode.sv
module extirq_decode
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output strobe_t           st
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_PINS);

  logic isCtrl;
  logic isSel;

  always_comb begin
    isCtrl    = (busAddr < SEL_ADDR);
    isSel     = (busAddr == SEL_ADDR);
    st.rdCtrl = isCtrl;
    st.rdSel  = isSel;
    st.wrCtrl = busWrEn && isCtrl;
    st.wrSel  = busWrEn && isSel;
    st.pinIdx = busAddr[IDX_W-1:0];
    st.wdata  = busWrData;
  end
endmodule

// File: rtl/extirq_dp.sv
module extirq_dp
  import extirq_pkg::*;
#(
  parameter int NUM_PINS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PINS-1:0]       pinIn,
  input  strobe_t                   st,
  output logic [7:0]                rdData,
  output logic [NUM_PINS-1:0]       reqOut,
  output logic [LVL_W*NUM_PINS-1:0] levelOut,
  output logic [NUM_PINS-1:0]       flagVec,
  output logic [NUM_PINS-1:0]       edgeHit
);
  logic [SYNC_STAGES-1:0] syncReg [NUM_PINS];
  logic [NUM_PINS-1:0]    prevReg;
  logic [LVL_W-1:0]       lvl     [NUM_PINS];
  logic [NUM_PINS-1:0]    pol;
  logic [NUM_PINS-1:0]    rsv;
  logic [NUM_PINS-1:0]    bothSel;
  logic                   unusedHi;

  assign unusedHi = ^st.wdata[7:6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bothSel <= '0;
    else if (st.wrSel) bothSel <= st.wdata[NUM_PINS-1:0];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic syncNow;
    logic rise;
    logic fall;
    logic myWr;

    assign syncNow = syncReg[i][SYNC_STAGES-1];
    assign rise    = syncNow & ~prevReg[i];
    assign fall    = ~syncNow & prevReg[i];
    assign edgeHit[i] = bothSel[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign myWr    = st.wrCtrl && (st.pinIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncReg[i] <= '0;
        prevReg[i] <= 1'b0;
        lvl[i]     <= '0;
        pol[i]     <= 1'b0;
        rsv[i]     <= 1'b0;
        flagVec[i] <= 1'b0;
      end else begin
        syncReg[i] <= {syncReg[i][SYNC_STAGES-2:0], pinIn[i]};
        prevReg[i] <= syncNow;
        if (myWr) begin
          lvl[i] <= st.wdata[LVL_W-1:0];
          pol[i] <= st.wdata[POL_BIT];
          rsv[i] <= st.wdata[RSV_BIT];
        end
        // detected edge wins over a same-cycle software clear
        flagVec[i] <= edgeHit[i] | (flagVec[i] & ~(myWr & ~st.wdata[FLAG_BIT]));
      end
    end

    assign levelOut[LVL_W*i +: LVL_W] = lvl[i];
    assign reqOut[i] = flagVec[i] && (lvl[i] != '0);
  end

  always_comb begin
    rdData = '0;
    if (st.rdCtrl) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (st.pinIdx == IDX_W'(i)) begin
          rdData[LVL_W-1:0] = lvl[i];
          rdData[FLAG_BIT]  = flagVec[i];
          rdData[POL_BIT]   = pol[i];
          rdData[RSV_BIT]   = rsv[i];
        end
      end
    end else if (st.rdSel) begin
      rdData[NUM_PINS-1:0] = bothSel;
    end
  end
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_PINS    = 5,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PINS-1:0]       pinIn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busWrEn,
  input  logic [7:0]                busWrData,
  output logic [7:0]                busRdData,
  output logic [NUM_PINS-1:0]       reqOut,
  output logic [LVL_W*NUM_PINS-1:0] levelOut
);
  strobe_t             st;
  logic [NUM_PINS-1:0] flagVec;
  logic [NUM_PINS-1:0] edgeHit;

  extirq_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .st(st)
  );

  extirq_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .st(st), .rdData(busRdData),
    .reqOut(reqOut), .levelOut(levelOut), .flagVec(flagVec), .edgeHit(edgeHit)
  );
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk #(
  parameter int NUM_PINS = 5,
  parameter int ADDR_W   = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWrEn,
  input logic                  wrFlagBit,
  input logic [1:0]            rdTop,
  input logic [NUM_PINS-1:0]   reqOut,
  input logic [3*NUM_PINS-1:0] levelOut,
  input logic [NUM_PINS-1:0]   flagVec,
  input logic [NUM_PINS-1:0]   edgeHit
);
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_W'(NUM_PINS)) |-> (rdTop == 2'b00)); // R2

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
      (!flagVec[i] && !edgeHit[i]) |=> !flagVec[i]); // R6
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[i] |=> flagVec[i]); // R7
    AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
      reqOut[i] |-> (flagVec[i] && levelOut[3*i +: 3] != 3'd0)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flagVec[i] && !(busWrEn && busAddr == ADDR_W'(i) && !wrFlagBit)) |=> flagVec[i]); // R10
  end
endmodule

bind extirq_ctrl extirq_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .wrFlagBit(busWrData[3]), .rdTop(busRdData[7:6]), .reqOut(reqOut),
  .levelOut(levelOut), .flagVec(flagVec), .edgeHit(edgeHit)
);

// File: tb/extirq_ctrl_test.sv
`timescale 1ns/1ps
module extirq_ctrl_test;
  localparam int NP = 5;
  localparam int AW = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP-1:0]   pinIn = '0;
  logic [AW-1:0]   busAddr = '0;
  logic            busWrEn = 1'b0;
  logic [7:0]      busWrData = '0;
  logic [7:0]      busRdData;
  logic [NP-1:0]   reqOut;
  logic [3*NP-1:0] levelOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  extirq_ctrl uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .reqOut(reqOut), .levelOut(levelOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = AW'(addr); busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [7:0] data);
    @(negedge clk);
    busAddr = AW'(addr);
    #1 data = busRdData;
  endtask

  task automatic flagIs(input int pin, input bit exp, input string tag);
    logic [7:0] d;
    busRead(pin, d);
    check(d[3] == exp, tag, d[3], exp);
  endtask

  task automatic drivePin(input int pin, input bit v);
    @(negedge clk);
    pinIn[pin] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a <= NP; a++) begin
      busRead(a, d);
      check(d == 8'h00, "R1 register reset", d, 0);
    end
    check(reqOut == '0, "R1 reqOut reset", reqOut, 0);
    check(levelOut == '0, "R1 levelOut reset", levelOut, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    busWrite(2, 8'hFF);
    busRead(2, d);
    check(d == 8'h37, "R2 ctrl readback", d, 8'h37);
    busRead(1, d);
    check(d == 8'h00, "R2 neighbour untouched", d, 0);
    check(levelOut == 15'(7 << 6), "R9 level field position", levelOut, 7 << 6);
    busWrite(NP, 8'hFF);
    busRead(NP, d);
    check(d == 8'h1F, "R2 select readback", d, 8'h1F);
    busRead(9, d);
    check(d == 8'h00, "R2 unmapped read", d, 0);
    busWrite(2, 8'h00);
    busWrite(NP, 8'h00);
    check(levelOut == '0, "R9 level cleared", levelOut, 0);
  endtask

  task automatic t_falling();
    busWrite(0, 8'h01);
    drivePin(0, 1'b1);
    flagIs(0, 1'b0, "R3 rising ignored");
    drivePin(0, 1'b0);
    flagIs(0, 1'b1, "R3 falling sets");
    check(reqOut[0] == 1'b1, "R8 request raised", reqOut[0], 1);
    busWrite(0, 8'h01);
    check(reqOut[0] == 1'b0, "R6 clear drops request", reqOut[0], 0);
  endtask

  task automatic t_rising();
    busWrite(1, 8'h12);
    drivePin(1, 1'b1);
    flagIs(1, 1'b1, "R4 rising sets");
    busWrite(1, 8'h12);
    drivePin(1, 1'b0);
    flagIs(1, 1'b0, "R4 falling ignored");
  endtask

  task automatic t_both();
    busWrite(NP, 8'h08);
    busWrite(3, 8'h03);
    drivePin(3, 1'b1);
    flagIs(3, 1'b1, "R5 rising in both mode");
    busWrite(3, 8'h03);
    drivePin(3, 1'b0);
    flagIs(3, 1'b1, "R5 falling in both mode");
  endtask

  task automatic t_clear();
    busWrite(3, 8'h0B);
    flagIs(3, 1'b1, "R6 write one keeps pending");
    busWrite(3, 8'h03);
    flagIs(3, 1'b0, "R6 write zero clears");
    busWrite(3, 8'h0B);
    flagIs(3, 1'b0, "R6 write one cannot set");
  endtask

  task automatic t_latency();
    busWrite(4, 8'h15);
    @(negedge clk);
    pinIn[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(reqOut[4] == 1'b0, "R10 no early set", reqOut[4], 0);
    @(posedge clk);
    @(negedge clk);
    check(reqOut[4] == 1'b1, "R10 set at third edge", reqOut[4], 1);
    drivePin(4, 1'b0);
    flagIs(4, 1'b1, "R10 sticky after pin returns");
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk);
    pinIn[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = AW'(4); busWrData = 8'h15; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    flagIs(4, 1'b1, "R7 edge wins over clear");
    busWrite(4, 8'h15);
    busRead(4, d);
    check(d == 8'h15, "R7 clear without edge", d, 8'h15);
  endtask

  task automatic t_gate();
    busWrite(0, 8'h00);
    drivePin(0, 1'b1);
    drivePin(0, 1'b0);
    flagIs(0, 1'b1, "R8 flag latches at level 0");
    check(reqOut[0] == 1'b0, "R8 level 0 gates request", reqOut[0], 0);
    busWrite(0, 8'h0B);
    check(reqOut[0] == 1'b1, "R8 request after level raised", reqOut[0], 1);
    check(levelOut[2:0] == 3'd3, "R9 pin0 level", levelOut[2:0], 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_falling();
    t_rising();
    t_both();
    t_clear();
    t_latency();
    t_collide();
    t_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule